// File: doc/BRIEF.md
# Multiframe overhead byte generator

This block produces one overhead byte per transport frame for a fault reporting channel. Over a multiframe of 256 frames the bytes come from one of four sources, chosen by a 2-bit select. The first source is a 256-byte table kept in a 128-word by 16-bit stack. The second is an external byte input. The third is the byte taken from the incoming frame, which serves the loopback paths. The fourth code is reserved and gives zeros.

A processor fills the table through two register addresses. One holds a 7-bit pointer and the other is a data window. Every read or write of the data window moves the pointer on by one entry, so a whole table can be loaded or dumped with back-to-back accesses to a single address. Each frame-start strobe registers the byte selected for the current multiframe index onto the output and then advances the index.

Top module: `mfo_byte_gen`

## Requirements
- R1: A synchronous active-high reset clears the stack pointer, the multiframe byte index and the output byte to zero.
- R2: A write to register address 0 loads the pointer from data bits 6:0, and higher data bits are ignored. A read of address 0 returns the pointer in bits 6:0 with zeros above, one cycle after the read strobe.
- R3: A write to register address 1 stores the 16-bit data word in the stack entry named by the pointer. A read of address 1 returns that entry one cycle after the read strobe.
- R4: Each read or write of address 1 advances the pointer by one in the following cycle, and the pointer wraps from 127 to 0. No other access changes the pointer except a write to address 0.
- R5: With select 00, the byte for index i comes from stack entry i/2: bits 15:8 for an even i and bits 7:0 for an odd i.
- R6: With select 01, the output byte is the external byte input sampled at the frame-start strobe.
- R7: With select 10, the output byte is the received-frame byte sampled at the frame-start strobe.
- R8: With select 11, the output byte is zero.
- R9: The output byte changes only in the cycle after a frame-start strobe. A change of select or of the source inputs between strobes has no effect until the next strobe.
- R10: The byte index advances by one on each frame-start strobe and wraps from 255 to 0. The byte issued on a strobe is the one for the index value before that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 1 | Register address: 0 selects the pointer, 1 selects the data window |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| src_sel | input | 2 | Byte source: 00 table, 01 external, 10 received, 11 zero |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| ext_byte | input | 8 | Byte from external logic |
| rx_byte | input | 8 | Byte taken from the received frame |
| byte_idx | output | 8 | Multiframe index of the next byte to be issued |
| oh_byte | output | 8 | Registered overhead byte |

## Verification
On every cycle, the assertions check that the pointer steps by exactly one on each data access and holds when there is no access. They also check that the index steps on each strobe, that the output holds between strobes, and that the external, received and reserved codes give the input byte or zero. The bench's scenarios are needed to show table contents: that a word written through the data window comes back on a read and appears, high byte first, at the matching multiframe indices. They also show the pointer wrap at 127, the index wrap at 255 across a full multiframe, and that a change of select takes effect only at the next strobe.

// File: rtl/mfo_pkg.sv
package mfo_pkg;
  typedef enum logic [1:0] {
    SRC_TABLE = 2'b00,
    SRC_EXT   = 2'b01,
    SRC_RX    = 2'b10,
    SRC_NONE  = 2'b11
  } src_e;

  localparam logic REG_PTR  = 1'b0;
  localparam logic REG_DATA = 1'b1;
endpackage

// File: rtl/mfo_ptr.sv
module mfo_ptr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (ld)   ptr <= ld_val;
    else if (step) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/mfo_ram.sv
module mfo_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 128,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [AW-1:0]     b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/mfo_out.sv
module mfo_out #(
  parameter int BYTE_W = 8,
  parameter int DATA_W = 16,
  parameter int AW     = 7,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int LW    = $clog2(LANES),
  localparam int IDX_W = AW + LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs,
  input  logic [1:0]        sel,
  input  logic [BYTE_W-1:0] ext_byte,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] word,
  output logic [AW-1:0]     word_addr,
  output logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] oh_byte
);
  import mfo_pkg::*;

  logic [BYTE_W-1:0] lane_byte [LANES];
  logic [LW-1:0]     lane;
  logic [BYTE_W-1:0] tbl_byte;
  logic [BYTE_W-1:0] nxt_byte;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = word[DATA_W-1-g*BYTE_W -: BYTE_W];
  end

  assign lane      = idx[LW-1:0];
  assign word_addr = idx[IDX_W-1:LW];
  assign tbl_byte  = lane_byte[lane];

  always_comb begin
    unique case (src_e'(sel))
      SRC_TABLE: nxt_byte = tbl_byte;
      SRC_EXT:   nxt_byte = ext_byte;
      SRC_RX:    nxt_byte = rx_byte;
      default:   nxt_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      oh_byte <= '0;
    end else if (fs) begin
      idx     <= idx + 1'b1;
      oh_byte <= nxt_byte;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fs |=> $stable(oh_byte)); // R9
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    fs |=> idx == $past(idx) + 1'b1); // R10
  AST_EXT_PASS: assert property (@(posedge clk) disable iff (rst)
    (fs && sel == 2'b01) |=> oh_byte == $past(ext_byte)); // R6
  AST_RX_PASS: assert property (@(posedge clk) disable iff (rst)
    (fs && sel == 2'b10) |=> oh_byte == $past(rx_byte)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fs && sel == 2'b11) |=> oh_byte == '0); // R8
endmodule

// File: rtl/mfo_byte_gen.sv
module mfo_byte_gen #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 128,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int IDX_W = AW + $clog2(DATA_W / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [1:0]        src_sel,
  input  logic              frame_start,
  input  logic [BYTE_W-1:0] ext_byte,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [BYTE_W-1:0] oh_byte
);
  import mfo_pkg::*;

  logic              ptr_ld, data_wr, data_rd, data_acc;
  logic [AW-1:0]     ptr, word_addr;
  logic [DATA_W-1:0] ram_qa, ram_qb;
  logic              rsel_q;
  logic [AW-1:0]     ptr_snap_q;

  assign ptr_ld   = cpu_wr && (cpu_addr == REG_PTR);
  assign data_wr  = cpu_wr && (cpu_addr == REG_DATA);
  assign data_rd  = cpu_rd && !cpu_wr && (cpu_addr == REG_DATA);
  assign data_acc = data_wr || data_rd;

  mfo_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .ld(ptr_ld), .ld_val(cpu_wdata[AW-1:0]),
    .step(data_acc), .ptr(ptr)
  );

  mfo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .a_we(data_wr), .a_re(data_rd), .a_addr(ptr),
    .a_wdata(cpu_wdata), .a_rdata(ram_qa), .b_addr(word_addr), .b_rdata(ram_qb)
  );

  mfo_out #(.BYTE_W(BYTE_W), .DATA_W(DATA_W), .AW(AW)) u_out (
    .clk(clk), .rst(rst), .fs(frame_start), .sel(src_sel),
    .ext_byte(ext_byte), .rx_byte(rx_byte), .word(ram_qb),
    .word_addr(word_addr), .idx(byte_idx), .oh_byte(oh_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q     <= REG_PTR;
      ptr_snap_q <= '0;
    end else if (cpu_rd) begin
      rsel_q     <= cpu_addr;
      ptr_snap_q <= ptr;
    end
  end

  assign cpu_rdata = (rsel_q == REG_DATA) ? ram_qa
                                          : {{(DATA_W-AW){1'b0}}, ptr_snap_q};

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    ((cpu_wr || cpu_rd) && cpu_addr == REG_DATA) |=> ptr == $past(ptr) + 1'b1); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cpu_wr && !(cpu_rd && cpu_addr == REG_DATA)) |=> $stable(ptr)); // R4
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == REG_PTR) |=> ptr == $past(cpu_wdata[AW-1:0])); // R2
endmodule

// File: tb/sim_mfo_byte_gen.sv
module sim_mfo_byte_gen;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        cpu_addr = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [1:0]  src_sel = 2'b00;
  logic        frame_start = 1'b0;
  logic [7:0]  ext_byte = '0, rx_byte = '0;
  logic [7:0]  byte_idx, oh_byte;

  mfo_byte_gen u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [15:0] model [128];
  int m_idx = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic cpu_write(logic a, logic [15:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(logic a, logic [15:0] exp, string tag);
    cpu_addr = a; cpu_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    cpu_rd = 1'b0;
    check(tag, cpu_rdata, exp);
  endtask

  task automatic frame(logic [1:0] s, logic [7:0] e, logic [7:0] r, string tag);
    logic [15:0] w;
    logic [7:0]  b;
    case (s)
      2'b00: begin w = model[m_idx >> 1]; b = m_idx[0] ? w[7:0] : w[15:8]; end
      2'b01: b = e;
      2'b10: b = r;
      default: b = 8'h00;
    endcase
    m_idx = (m_idx + 1) % 256;
    exp_q.push_back({m_idx[7:0], b});
    tag_q.push_back(tag);
    src_sel = s; ext_byte = e; rx_byte = r; frame_start = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_start = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  // monitor: pop the expected item for each strobe and compare
  initial forever begin
    @(posedge clk);
    if (frame_start && !rst) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check("R10 unexpected strobe", 16'h0, 16'h1);
      end else begin
        logic [15:0] it;
        string t;
        it = exp_q.pop_front();
        t  = tag_q.pop_front();
        check({t, " byte"}, {8'h00, oh_byte}, {8'h00, it[7:0]});
        check("R10 index", {8'h00, byte_idx}, {8'h00, it[15:8]});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 oh_byte", {8'h00, oh_byte}, 16'h0000);
    check("R1 byte_idx", {8'h00, byte_idx}, 16'h0000);
    cpu_read(1'b0, 16'h0000, "R1 pointer");
    // R2 pointer access, upper bits ignored
    cpu_write(1'b0, 16'h0005);
    cpu_read(1'b0, 16'h0005, "R2 pointer readback");
    cpu_write(1'b0, 16'hFFFF);
    cpu_read(1'b0, 16'h007F, "R2 pointer masked");
    // R4 wrap 127 -> 0 on a data write
    cpu_write(1'b1, 16'hABCD);
    model[127] = 16'hABCD;
    cpu_read(1'b0, 16'h0000, "R4 pointer wrap");
    // R3 fill the whole table
    for (int i = 0; i < 128; i++) begin
      logic [15:0] w;
      w = (16'(i) * 16'h0101) ^ 16'h5A3C;
      model[i] = w;
      cpu_write(1'b1, w);
    end
    cpu_read(1'b0, 16'h0000, "R4 pointer after 128 writes");
    cpu_write(1'b0, 16'd10);
    cpu_read(1'b1, model[10], "R3 data read");
    cpu_read(1'b1, model[11], "R3 data read after increment");
    cpu_read(1'b0, 16'd12, "R4 pointer after two reads");
    // R5 and R10: full multiframe from the table, index wraps
    for (int i = 0; i < 256; i++) frame(2'b00, 8'hEE, 8'hDD, "R5 table");
    check("R10 index wrapped", {8'h00, byte_idx}, 16'h0000);
    frame(2'b01, 8'h3E, 8'hC7, "R6 external");
    frame(2'b10, 8'h3E, 8'hC7, "R7 received");
    frame(2'b11, 8'hFF, 8'hFF, "R8 reserved");
    frame(2'b00, 8'h3E, 8'hC7, "R5 table after other codes");
    frame(2'b10, 8'h11, 8'h44, "R7 received");
    // R9 no strobe: select and inputs change, output holds
    src_sel = 2'b01; ext_byte = 8'h99; rx_byte = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 hold without strobe", {8'h00, oh_byte}, 16'h0044);
    frame(2'b01, 8'h99, 8'h00, "R9 new select at next frame");
    // R3 rewrite one entry and see it on the output
    cpu_write(1'b0, 16'd2);
    cpu_write(1'b1, 16'h1234);
    model[2] = 16'h1234;
    cpu_write(1'b0, 16'd2);
    cpu_read(1'b1, 16'h1234, "R3 rewrite readback");
    while (m_idx != 4) frame(2'b11, 8'h00, 8'h00, "R8 reserved");
    frame(2'b00, 8'h00, 8'h00, "R5 even index high byte");
    frame(2'b00, 8'h00, 8'h00, "R5 odd index low byte");
    repeat (2) @(negedge clk);
    check("R10 queue drained", 16'(exp_q.size()), 16'h0000);
    report();
    $finish;
  end
endmodule